// File: doc/BRIEF.md
# Serial Interrupt Slot Driver

This block places one device's interrupt request on a shared serialized interrupt line. A frame sequencer outside the block marks the start of each frame and steps through the numbered slots. When the current slot equals the device's programmed channel number, the block may pull the line for that one slot. The line is open-drain style: the block drives it only in its own slot and leaves it released in every other cycle.

A one-byte channel-select register sets the channel number, a sharing enable and a two-bit signalling style. After reset the channel number comes from strap inputs. Software can then rewrite it. There are three signalling styles: active-low level, active-low single pulse per new interrupt, and active-high level. The fourth code is reserved and silences the device. With sharing off, the device always signals active-low level. A modem-control output-gate bit also has to be set before anything is driven.

Two state machines do the work. The output machine has three states: DRV_RELEASE, DRV_LOW and DRV_HIGH. In each cycle it moves to DRV_LOW or DRV_HIGH when the slot matches, the gate is open and the selected style calls for a drive. Otherwise it moves to DRV_RELEASE. The pulse machine is used only in the single-pulse style and has four states:
- ARM_IDLE goes to ARM_WAIT_FRAME on a rising interrupt.
- ARM_WAIT_FRAME goes to ARM_READY on a frame start.
- ARM_READY goes to ARM_SPENT when the pulse is sent and the interrupt is still high. It goes to ARM_IDLE when the pulse is sent and the interrupt is low.
- ARM_SPENT goes to ARM_IDLE when the interrupt falls.
- Leaving the single-pulse style forces ARM_IDLE.

Top module: `sirq_slot_driver`

## Requirements
- R1: After reset, `cfg_rdata` equals `{3'b000, 1'b0, strap_chan}`, `sirq_oe` is 0 and `sirq_data` is 1.
- R2: A write with `cfg_wr_en` updates the register. The field layout is: channel in bits [3:0], sharing enable in bit 4, style in bits [6:5]. Bit 7 is ignored on write and always reads 0.
- R3: `sirq_oe` is 1 for exactly the one cycle after a cycle in which `slot_valid` is 1 and `slot_num` equals the channel number. In no other cycle is it 1.
- R4: If `out_gate` is 0 in the matching slot cycle, nothing is driven in the following cycle.
- R5: With sharing disabled (bit 4 = 0), the device behaves as active-low level, whatever the style field holds.
- R6: Style 00 with sharing on: in every frame in which `irq_pend` is 1 at the matching slot, the device drives `sirq_oe`=1, `sirq_data`=0. When `irq_pend` is 0, it drives nothing.
- R7: Style 01 with sharing on: a rising `irq_pend` produces exactly one low pulse. Another pulse needs `irq_pend` to fall and rise again.
- R8: Style 10 with sharing on: while `irq_pend` is 1, the matching slot drives `sirq_oe`=1, `sirq_data`=1.
- R9: Style 11 with sharing on: the device never drives the line.
- R10: Whenever `sirq_oe` is 0, `sirq_data` is 1.
- R11: In style 01, the pulse armed by a rise is sent in the matching slot of the next frame after the rise, never in the frame where the rise occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_chan | input | 4 | Reset value of the channel number |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data |
| irq_pend | input | 1 | Device interrupt pending |
| out_gate | input | 1 | Modem-control output-gate bit |
| frame_start | input | 1 | One-cycle pulse at the start of a frame |
| slot_valid | input | 1 | Marks a cycle that carries a slot |
| slot_num | input | 4 | Slot index of the current cycle |
| sirq_oe | output | 1 | Drive enable for the shared line |
| sirq_data | output | 1 | Value driven when enabled |

## Verification
The hardest case to reach is the single-pulse style. It needs a rise that lands after the device's slot has already passed in the current frame. It also needs `irq_pend` to stay high across several frames, then fall and rise again, so that the armed, sent and spent paths are all exercised. The stimulus raises the interrupt partway through one frame, at a slot number chosen relative to the channel. It then holds the level for two frames, drops it for one frame, and raises it again late in a later frame. The scoreboard expects exactly one low pulse in each of those sequences.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
    typedef enum logic [1:0] {
        SM_LOW_LEVEL  = 2'b00,
        SM_LOW_EDGE   = 2'b01,
        SM_HIGH_LEVEL = 2'b10,
        SM_RESERVED   = 2'b11
    } sig_mode_e;

    typedef enum logic [1:0] {
        ARM_IDLE,
        ARM_WAIT_FRAME,
        ARM_READY,
        ARM_SPENT
    } arm_state_e;

    typedef enum logic [1:0] {
        DRV_RELEASE,
        DRV_LOW,
        DRV_HIGH
    } drv_state_e;
endpackage

// File: rtl/sirq_cfg_reg.sv
module sirq_cfg_reg
    import sirq_pkg::*;
#(
    parameter int SLOT_W = 4,
    localparam int CFG_W = SLOT_W + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] strap_chan,
    input  logic              wr_en,
    input  logic [CFG_W-1:0]  wdata,
    output logic [CFG_W-1:0]  rdata,
    output logic [SLOT_W-1:0] chan,
    output sig_mode_e         eff_mode
);
    localparam int SHARE_BIT = SLOT_W;
    localparam int MODE_LO   = SLOT_W + 1;

    logic      share_q;
    sig_mode_e mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan    <= strap_chan;
            share_q <= 1'b0;
            mode_q  <= SM_LOW_LEVEL;
        end else if (wr_en) begin
            chan    <= wdata[SLOT_W-1:0];
            share_q <= wdata[SHARE_BIT];
            mode_q  <= sig_mode_e'(wdata[MODE_LO+1:MODE_LO]);
        end
    end

    always_comb begin
        rdata = {1'b0, mode_q, share_q, chan};
        eff_mode = share_q ? mode_q : SM_LOW_LEVEL;
    end

    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rdata[CFG_W-2:0] == $past(wdata[CFG_W-2:0])));
endmodule

// File: rtl/sirq_edge_arm.sv
module sirq_edge_arm
    import sirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic edge_mode,
    input  logic pend,
    input  logic frame_start,
    input  logic fire,
    output logic pulse_due
);
    arm_state_e state_q, state_d;
    logic       pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARM_IDLE;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend;
        end
    end

    always_comb begin
        state_d = state_q;
        if (!edge_mode) begin
            state_d = ARM_IDLE;
        end else begin
            unique case (state_q)
                ARM_IDLE:       if (pend && !pend_q) state_d = ARM_WAIT_FRAME;
                ARM_WAIT_FRAME: if (frame_start) state_d = ARM_READY;
                ARM_READY:      if (fire) state_d = pend ? ARM_SPENT : ARM_IDLE;
                ARM_SPENT:      if (!pend) state_d = ARM_IDLE;
                default:        state_d = ARM_IDLE;
            endcase
        end
    end

    always_comb pulse_due = (state_q == ARM_READY);

    // R7: a sent pulse is never followed by another without re-arming
    a_r7_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !pulse_due);
    // R11: a pulse becomes due only after a frame boundary
    a_r11_next_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_due && !$past(pulse_due)) |-> $past(frame_start));
endmodule

// File: rtl/sirq_slot_drv.sv
module sirq_slot_drv
    import sirq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      slot_hit,
    input  logic      gate,
    input  logic      pend,
    input  sig_mode_e eff_mode,
    input  logic      pulse_due,
    output logic      fire,
    output logic      oe,
    output logic      data
);
    drv_state_e state_q, state_d;
    logic       open_slot;

    always_comb begin
        open_slot = slot_hit && gate;
        fire      = open_slot && pulse_due && (eff_mode == SM_LOW_EDGE);
        state_d   = DRV_RELEASE;
        if (open_slot) begin
            unique case (eff_mode)
                SM_LOW_LEVEL:  if (pend) state_d = DRV_LOW;
                SM_LOW_EDGE:   if (pulse_due) state_d = DRV_LOW;
                SM_HIGH_LEVEL: if (pend) state_d = DRV_HIGH;
                SM_RESERVED:   state_d = DRV_RELEASE;
                default:       state_d = DRV_RELEASE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DRV_RELEASE;
        else        state_q <= state_d;
    end

    always_comb begin
        oe   = 1'b0;
        data = 1'b1;
        unique case (state_q)
            DRV_RELEASE: begin oe = 1'b0; data = 1'b1; end
            DRV_LOW:     begin oe = 1'b1; data = 1'b0; end
            DRV_HIGH:    begin oe = 1'b1; data = 1'b1; end
            default:     begin oe = 1'b0; data = 1'b1; end
        endcase
    end

    a_r4_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
        !gate |=> !oe);
    a_r9_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_mode == SM_RESERVED) |=> !oe);
    a_r8_high_only_in_high_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && data) |-> $past(eff_mode == SM_HIGH_LEVEL));
endmodule

// File: rtl/sirq_slot_driver.sv
module sirq_slot_driver
    import sirq_pkg::*;
#(
    parameter int SLOT_W = 4,
    localparam int CFG_W = SLOT_W + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] strap_chan,
    input  logic              cfg_wr_en,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              irq_pend,
    input  logic              out_gate,
    input  logic              frame_start,
    input  logic              slot_valid,
    input  logic [SLOT_W-1:0] slot_num,
    output logic              sirq_oe,
    output logic              sirq_data
);
    logic [SLOT_W-1:0] chan;
    sig_mode_e         eff_mode;
    logic              slot_hit;
    logic              pulse_due;
    logic              fire;

    sirq_cfg_reg #(.SLOT_W(SLOT_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_chan (strap_chan),
        .wr_en      (cfg_wr_en),
        .wdata      (cfg_wdata),
        .rdata      (cfg_rdata),
        .chan       (chan),
        .eff_mode   (eff_mode)
    );

    always_comb slot_hit = slot_valid && (slot_num == chan);

    sirq_edge_arm u_arm (
        .clk         (clk),
        .rst_n       (rst_n),
        .edge_mode   (eff_mode == SM_LOW_EDGE),
        .pend        (irq_pend),
        .frame_start (frame_start),
        .fire        (fire),
        .pulse_due   (pulse_due)
    );

    sirq_slot_drv u_drv (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_hit  (slot_hit),
        .gate      (out_gate),
        .pend      (irq_pend),
        .eff_mode  (eff_mode),
        .pulse_due (pulse_due),
        .fire      (fire),
        .oe        (sirq_oe),
        .data      (sirq_data)
    );

    a_r3_own_slot_only: assert property (@(posedge clk) disable iff (!rst_n)
        sirq_oe |-> $past(slot_valid && (slot_num == chan)));
    a_r3_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (sirq_oe && !$past(slot_valid)) |-> 1'b0);
endmodule

// File: tb/sirq_slot_driver_tb.sv
module sirq_slot_driver_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        int    due;
        bit    oe;
        bit    data;
        string req;
    } exp_t;

    logic       clk = 0;
    logic       rst_n = 0;
    logic [3:0] strap_chan = 4'd9;
    logic       cfg_wr_en = 0;
    logic [7:0] cfg_wdata = 0;
    logic [7:0] cfg_rdata;
    logic       irq_pend = 0;
    logic       out_gate = 1;
    logic       frame_start = 0;
    logic       slot_valid = 0;
    logic [3:0] slot_num = 0;
    logic       sirq_oe;
    logic       sirq_data;

    int   cyc = 0;
    int   total = 0;
    int   bad = 0;
    int   chan_tb = 9;
    exp_t q[$];
    exp_t item;

    sirq_slot_driver u_dut (
        .clk(clk), .rst_n(rst_n), .strap_chan(strap_chan),
        .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .irq_pend(irq_pend), .out_gate(out_gate), .frame_start(frame_start),
        .slot_valid(slot_valid), .slot_num(slot_num),
        .sirq_oe(sirq_oe), .sirq_data(sirq_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string req, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // monitor: compare outputs against scoreboard items when due
    always @(negedge clk) begin
        if (q.size() > 0 && q[0].due == cyc) begin
            item = q.pop_front();
            chk(sirq_oe == item.oe && sirq_data == item.data, item.req,
                {sirq_oe, sirq_data}, {item.oe, item.data});
        end
    end

    task automatic step(bit fs, bit sv, int sn, bit pend, bit gate,
                        bit e_oe, bit e_data, string req);
        exp_t e;
        @(negedge clk);
        frame_start = fs;
        slot_valid  = sv;
        slot_num    = sn[3:0];
        irq_pend    = pend;
        out_gate    = gate;
        e.due  = cyc + 1;
        e.oe   = e_oe;
        e.data = e_data;
        e.req  = req;
        q.push_back(e);
    endtask

    task automatic do_frame(int rise_at, bit pend_base, bit gate,
                            bit act, bit dval, string req);
        step(1'b1, 1'b0, 0, pend_base, gate, 1'b0, 1'b1, {req, " R10"});
        for (int s = 0; s < 16; s++) begin
            bit p;
            bit hit;
            p   = (rise_at >= 0 && s >= rise_at) ? 1'b1 : pend_base;
            hit = (s == chan_tb) && act;
            step(1'b0, 1'b1, s, p, gate, hit, hit ? dval : 1'b1,
                 hit ? {req, " R3"} : {req, " R3 R10"});
        end
        step(1'b0, 1'b0, 0, irq_pend, gate, 1'b0, 1'b1, {req, " R10"});
    endtask

    task automatic wr_cfg(logic [7:0] v, logic [7:0] exp_rd, string req);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        chk(cfg_rdata == exp_rd, req, cfg_rdata, exp_rd);
        chan_tb = int'(v[3:0]);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cfg_rdata == 8'h09, "R1 rdata", cfg_rdata, 8'h09);
        chk(sirq_oe == 1'b0, "R1 oe", sirq_oe, 0);
        chk(sirq_data == 1'b1, "R1 R10 data", sirq_data, 1);

        // non-sharing default: active-low level on strap channel
        do_frame(-1, 1'b1, 1'b1, 1'b1, 1'b0, "R5 strap");

        // style 00, sharing on, channel 5
        wr_cfg(8'h15, 8'h15, "R2 write");
        do_frame(-1, 1'b1, 1'b1, 1'b1, 1'b0, "R6 frame1");
        do_frame(-1, 1'b1, 1'b1, 1'b1, 1'b0, "R6 frame2");
        do_frame(-1, 1'b0, 1'b1, 1'b0, 1'b1, "R6 cleared");
        do_frame(-1, 1'b1, 1'b0, 1'b0, 1'b1, "R4 gate");

        // style 01; bit 7 written as 1 must read 0
        do_frame(-1, 1'b0, 1'b1, 1'b0, 1'b1, "R6 idle");
        wr_cfg(8'hB5, 8'h35, "R2 bit7");
        do_frame(2, 1'b0, 1'b1, 1'b0, 1'b1, "R11 rise frame");
        do_frame(-1, 1'b1, 1'b1, 1'b1, 1'b0, "R7 R11 pulse");
        do_frame(-1, 1'b1, 1'b1, 1'b0, 1'b1, "R7 no repeat");
        do_frame(-1, 1'b0, 1'b1, 1'b0, 1'b1, "R7 low");
        do_frame(8, 1'b0, 1'b1, 1'b0, 1'b1, "R11 late rise");
        do_frame(-1, 1'b1, 1'b1, 1'b1, 1'b0, "R7 rearm pulse");

        // style 10
        wr_cfg(8'h55, 8'h55, "R2 high");
        do_frame(-1, 1'b1, 1'b1, 1'b1, 1'b1, "R8 high");
        do_frame(-1, 1'b0, 1'b1, 1'b0, 1'b1, "R8 cleared");

        // style 11
        wr_cfg(8'h75, 8'h75, "R2 reserved");
        do_frame(-1, 1'b1, 1'b1, 1'b0, 1'b1, "R9 reserved");

        // sharing off with style 10 in the field: still active-low
        wr_cfg(8'h4C, 8'h4C, "R2 nonshare");
        do_frame(-1, 1'b1, 1'b1, 1'b1, 1'b0, "R5 nonshare");

        repeat (4) @(negedge clk);
        chk(q.size() == 0, "scoreboard drained", q.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule